// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by fetching the mapping from a two-level page table held in memory. A requester presents a 32-bit virtual address. The walker splits it into three fields, from the top bits down: a directory index, a table index and a 4 KB page offset. It reads one entry from the directory and then, if that entry is usable, one entry from the page table it points to. The outcome goes back on a fill interface, ready to be loaded into the translation cache.

Each table is located by a frame number. For the directory, that frame is a base register loaded at a context switch. For a page table, it is the frame field of the directory entry. The walker handles one miss at a time. Its memory side is a single-outstanding read port: a request with a ready handshake, followed by a one-cycle response.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_req_valid` and `fill_valid` are 0.
- R2: When idle, a cycle with `miss_valid` high starts a walk, and `busy` reads 1 from the next cycle. A `miss_valid` that arrives while `busy` is 1 is ignored: it starts no walk and issues no memory read.
- R3: The first read of a walk goes to address `ctx_frame_base * 4096 + vaddr[31:22] * 4`.
- R4: An entry is usable when its bit 0 is 1, and its frame number is bits 31:12. After a usable directory entry, the second read goes to `dir_frame * 4096 + vaddr[21:12] * 4`.
- R5: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with an unchanged address.
- R6: A walk whose page table entry is usable ends with a one-cycle `fill_valid` pulse. On that pulse, `fill_fault` is 0, `fill_ppn` is entry bits 31:12, `fill_access` is entry bits 3:1, `fill_vpn` is vaddr[31:12], and `fill_paddr` is `{fill_ppn, vaddr[11:0]}`.
- R7: A directory entry with bit 0 clear ends the walk after one read. The fill pulse then carries `fill_fault` = 1 and `fill_lvl` = 0, with `fill_ppn`, `fill_access` and `fill_paddr` all 0.
- R8: A page table entry with bit 0 clear gives a fill pulse with `fill_fault` = 1 and `fill_lvl` = 1, with `fill_ppn`, `fill_access` and `fill_paddr` all 0. Exactly two reads are made.
- R9: A `ctx_load` pulse while idle replaces the directory base frame with `ctx_frame`. A `ctx_load` while busy leaves the base unchanged, so it does not affect later walks.
- R10: `fill_valid` lasts exactly one cycle. `busy` is 0 in the cycle after it, and `mem_req_valid` is never 1 unless `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_load | input | 1 | Load a new directory base frame (honoured when idle) |
| ctx_frame | input | 20 | New directory base frame number |
| miss_valid | input | 1 | Translation miss request |
| miss_vaddr | input | 32 | Virtual address that missed |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| fill_valid | output | 1 | Walk result, one-cycle pulse |
| fill_fault | output | 1 | Walk hit an invalid entry |
| fill_lvl | output | 1 | Level of the invalid entry: 0 directory, 1 table |
| fill_vpn | output | 20 | Virtual page number of the walk |
| fill_ppn | output | 20 | Physical page number found |
| fill_access | output | 3 | Access bits from the page table entry |
| fill_paddr | output | 32 | Translated physical address of the missing access |

## Verification
The checker assumes the memory port has at most one read in flight. A `mem_rsp_valid` pulse is expected only after an accepted request, and only before the next request is issued. The bench memory model enforces this. It withholds `mem_req_ready` while a response is pending, and it delivers that response one to three cycles after acceptance. Stray `miss_valid` and `ctx_load` pulses are driven only at points where the bench can predict their effect: during a walk, where both must be ignored, or in idle, where the base load takes effect.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    PW_IDLE     = 3'd0,
    PW_RD_DIR   = 3'd1,
    PW_WT_DIR   = 3'd2,
    PW_RD_TBL   = 3'd3,
    PW_WT_TBL   = 3'd4,
    PW_DONE     = 3'd5,
    PW_FAULT    = 3'd6
  } pw_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } pw_level_e;

endpackage

// File: rtl/pgwalk_base_reg.sv
module pgwalk_base_reg #(
  parameter int FRM_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             busy,
  input  logic [FRM_W-1:0] frame_in,
  output logic [FRM_W-1:0] base_q
);
  // the base is only replaced between walks
  always_ff @(posedge clk) begin
    if (!rst_n)
      base_q <= '0;
    else if (load && !busy)
      base_q <= frame_in;
  end
endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int FRM_W = 20,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32
) (
  input  logic             use_tbl,
  input  logic [FRM_W-1:0] base_frame,
  input  logic [FRM_W-1:0] dir_frame,
  input  logic [IDX_W-1:0] dir_idx,
  input  logic [IDX_W-1:0] tbl_idx,
  output logic [FRM_W+OFF_W-1:0] addr
);
  localparam int PA_W    = FRM_W + OFF_W;
  localparam int BYTE_SH = $clog2(ENT_W / 8);

  // byte address of entry 'idx' in the table occupying frame 'frm'
  function automatic logic [PA_W-1:0] entry_addr(input logic [FRM_W-1:0] frm,
                                                 input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] page;
    logic [PA_W-1:0] slot;
    page = {frm, {OFF_W{1'b0}}};
    slot = PA_W'(idx) << BYTE_SH;
    return page | slot;
  endfunction

  always_comb begin
    if (use_tbl)
      addr = entry_addr(dir_frame, tbl_idx);
    else
      addr = entry_addr(base_frame, dir_idx);
  end
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int ENT_W = 32,
  parameter int ACC_W = 3,
  parameter int VLD_B = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  miss_valid,
  input  logic [VA_W-1:0]       miss_vaddr,
  input  logic                  mem_req_ready,
  input  logic                  mem_rsp_valid,
  input  logic [ENT_W-1:0]      mem_rsp_data,
  output pw_state_e             state,
  output logic                  walk_start,
  output logic                  use_tbl,
  output logic                  req_valid,
  output logic [VA_W-1:0]       va_q,
  output logic [ENT_W-OFF_W-1:0] dir_frm_q,
  output logic [ENT_W-OFF_W-1:0] pte_frm_q,
  output logic [ACC_W-1:0]      pte_acc_q,
  output pw_level_e             lvl_q
);
  localparam int FRM_W = ENT_W - OFF_W;

  function automatic logic entry_ok(input logic [ENT_W-1:0] e);
    return e[VLD_B];
  endfunction

  function automatic logic [FRM_W-1:0] entry_frame(input logic [ENT_W-1:0] e);
    return e[ENT_W-1:OFF_W];
  endfunction

  function automatic logic [ACC_W-1:0] entry_access(input logic [ENT_W-1:0] e);
    return e[ACC_W:1];
  endfunction

  assign walk_start = (state == PW_IDLE) && miss_valid;
  assign use_tbl    = (state == PW_RD_TBL);
  assign req_valid  = (state == PW_RD_DIR) || (state == PW_RD_TBL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PW_IDLE;
      va_q      <= '0;
      dir_frm_q <= '0;
      pte_frm_q <= '0;
      pte_acc_q <= '0;
      lvl_q     <= LVL_DIR;
    end else begin
      case (state)
        PW_IDLE: begin
          if (miss_valid) begin
            va_q  <= miss_vaddr;
            state <= PW_RD_DIR;
          end
        end
        PW_RD_DIR: if (mem_req_ready) state <= PW_WT_DIR;
        PW_WT_DIR: begin
          if (mem_rsp_valid) begin
            dir_frm_q <= entry_frame(mem_rsp_data);
            if (entry_ok(mem_rsp_data)) begin
              state <= PW_RD_TBL;
            end else begin
              lvl_q <= LVL_DIR;
              state <= PW_FAULT;
            end
          end
        end
        PW_RD_TBL: if (mem_req_ready) state <= PW_WT_TBL;
        PW_WT_TBL: begin
          if (mem_rsp_valid) begin
            pte_frm_q <= entry_frame(mem_rsp_data);
            pte_acc_q <= entry_access(mem_rsp_data);
            if (entry_ok(mem_rsp_data)) begin
              state <= PW_DONE;
            end else begin
              lvl_q <= LVL_TBL;
              state <= PW_FAULT;
            end
          end
        end
        PW_DONE:  state <= PW_IDLE;
        PW_FAULT: state <= PW_IDLE;
        default:  state <= PW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10,
  parameter int ENT_W = 32,
  parameter int ACC_W = 3,
  parameter int VLD_B = 0,
  localparam int FRM_W = ENT_W - OFF_W,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = FRM_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctx_load,
  input  logic [FRM_W-1:0] ctx_frame,
  input  logic             miss_valid,
  input  logic [VA_W-1:0]  miss_vaddr,
  output logic             busy,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             fill_valid,
  output logic             fill_fault,
  output logic             fill_lvl,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [FRM_W-1:0] fill_ppn,
  output logic [ACC_W-1:0] fill_access,
  output logic [PA_W-1:0]  fill_paddr
);
  pw_state_e        state;
  pw_level_e        lvl_q;
  logic             walk_start;
  logic             use_tbl;
  logic             req_valid;
  logic [VA_W-1:0]  va_q;
  logic [FRM_W-1:0] dir_frm_q;
  logic [FRM_W-1:0] pte_frm_q;
  logic [ACC_W-1:0] pte_acc_q;
  logic [FRM_W-1:0] base_q;
  logic             ok_pulse;
  logic             bad_pulse;

  pgwalk_fsm #(
    .VA_W(VA_W), .OFF_W(OFF_W), .ENT_W(ENT_W), .ACC_W(ACC_W), .VLD_B(VLD_B)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .state(state), .walk_start(walk_start), .use_tbl(use_tbl),
    .req_valid(req_valid), .va_q(va_q), .dir_frm_q(dir_frm_q),
    .pte_frm_q(pte_frm_q), .pte_acc_q(pte_acc_q), .lvl_q(lvl_q)
  );

  pgwalk_base_reg #(.FRM_W(FRM_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load(ctx_load), .busy(busy),
    .frame_in(ctx_frame), .base_q(base_q)
  );

  pgwalk_addr #(
    .FRM_W(FRM_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
  ) u_addr (
    .use_tbl(use_tbl), .base_frame(base_q), .dir_frame(dir_frm_q),
    .dir_idx(va_q[VA_W-1 -: IDX_W]), .tbl_idx(va_q[OFF_W +: IDX_W]),
    .addr(mem_req_addr)
  );

  assign busy          = (state != PW_IDLE);
  assign mem_req_valid = req_valid;
  assign ok_pulse      = (state == PW_DONE);
  assign bad_pulse     = (state == PW_FAULT);

  assign fill_valid  = ok_pulse || bad_pulse;
  assign fill_fault  = bad_pulse;
  assign fill_lvl    = bad_pulse && (lvl_q == LVL_TBL);
  assign fill_vpn    = va_q[VA_W-1:OFF_W];
  assign fill_ppn    = ok_pulse ? pte_frm_q : '0;
  assign fill_access = ok_pulse ? pte_acc_q : '0;
  assign fill_paddr  = ok_pulse ? {pte_frm_q, va_q[OFF_W-1:0]} : '0;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int FRM_W = 20,
  parameter int ACC_W = 3,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             miss_valid,
  input logic             walk_start,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             fill_valid,
  input logic             fill_fault,
  input logic [FRM_W-1:0] fill_ppn,
  input logic [ACC_W-1:0] fill_access,
  input logic [PA_W-1:0]  fill_paddr,
  input logic [FRM_W-1:0] base_q
);
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |-> !busy && miss_valid);

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(miss_valid));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_fault_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_fault |-> fill_ppn == '0 && fill_access == '0 && fill_paddr == '0);

  assert_base_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q));

  assert_fill_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid && !busy);

  assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
endmodule

bind pgwalk_top pgwalk_chk #(.FRM_W(FRM_W), .ACC_W(ACC_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .miss_valid(miss_valid),
  .walk_start(walk_start), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_ppn(fill_ppn),
  .fill_access(fill_access), .fill_paddr(fill_paddr), .base_q(base_q)
);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctx_load = 1'b0;
  logic [19:0] ctx_frame = '0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic        busy;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        fill_valid, fill_fault, fill_lvl;
  logic [19:0] fill_vpn, fill_ppn;
  logic [2:0]  fill_access;
  logic [31:0] fill_paddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] mem [bit [31:0]];
  logic [31:0] log_a [4];
  int          log_n = 0;
  int          lat = 0;
  logic [31:0] pend = '0;
  logic [19:0] cur_base = '0;

  always #10 clk = ~clk;

  pgwalk_top uut (.*);

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] slot_addr(input logic [19:0] frm, input logic [9:0] idx);
    int unsigned v;
    v = int'(frm) * 4096 + int'(idx) * 4;
    return 32'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one read in flight, latency 1..3
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (lat > 0) begin
        mem_req_ready = 1'b0;
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend;
        end
      end else begin
        mem_req_ready = ($urandom % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
          if (log_n < 4) log_a[log_n] = mem_req_addr;
          log_n++;
          pend = rd(mem_req_addr);
          lat  = 1 + ($urandom % 3);
        end
      end
    end
  end

  task automatic set_base(input logic [19:0] f);
    @(negedge clk);
    ctx_load  = 1'b1;
    ctx_frame = f;
    @(negedge clk);
    ctx_load = 1'b0;
    cur_base = f;
  endtask

  task automatic make_map(input logic [31:0] va, input bit dir_ok, input bit pte_ok);
    logic [31:0] da, pa;
    logic [19:0] tf;
    da = slot_addr(cur_base, va[31:22]);
    tf = 20'h00100 + 20'($urandom % 64);
    if (!dir_ok) begin
      mem[da] = $urandom & 32'hFFFF_FFFE;
    end else begin
      mem[da] = {tf, 11'($urandom), 1'b1};
      pa = slot_addr(tf, va[21:12]);
      mem[pa] = pte_ok ? {20'($urandom), 11'($urandom), 1'b1} : ($urandom & 32'hFFFF_FFFE);
    end
  endtask

  // noise: 1 = stray miss during walk, 2 = stray ctx_load during walk
  task automatic walk(input logic [31:0] va, input int noise);
    logic [31:0] da, de, pa, pe;
    bit e_fault, e_lvl;
    int e_reads;
    logic [19:0] e_ppn;
    logic [2:0]  e_acc;
    da = slot_addr(cur_base, va[31:22]);
    de = rd(da);
    pa = slot_addr(de[31:12], va[21:12]);
    pe = rd(pa);
    if (!de[0]) begin
      e_fault = 1; e_lvl = 0; e_reads = 1; e_ppn = '0; e_acc = '0;
    end else if (!pe[0]) begin
      e_fault = 1; e_lvl = 1; e_reads = 2; e_ppn = '0; e_acc = '0;
    end else begin
      e_fault = 0; e_lvl = 0; e_reads = 2; e_ppn = pe[31:12]; e_acc = pe[3:1];
    end
    @(negedge clk);
    log_n = 0;
    miss_valid = 1'b1;
    miss_vaddr = va;
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy after miss", {31'b0, busy}, 32'd1);
    if (noise == 1) begin
      miss_vaddr = ~va;
    end else begin
      miss_valid = 1'b0;
      if (noise == 2) begin
        ctx_load  = 1'b1;
        ctx_frame = cur_base ^ 20'h00F0F;
      end
    end
    while (fill_valid !== 1'b1) @(negedge clk);
    miss_valid = 1'b0;
    ctx_load   = 1'b0;
    chk(log_n == e_reads, "R7/R8 read count", 32'(log_n), 32'(e_reads));
    chk(log_a[0] == da, "R3 directory address", log_a[0], da);
    if (e_reads == 2)
      chk(log_a[1] == pa, "R4 table address", log_a[1], pa);
    chk(fill_fault === e_fault, "R6/R7/R8 fault", {31'b0, fill_fault}, {31'b0, e_fault});
    if (e_fault)
      chk(fill_lvl === e_lvl, e_lvl ? "R8 level" : "R7 level", {31'b0, fill_lvl}, {31'b0, e_lvl});
    chk(fill_vpn === va[31:12], "R6 vpn", {12'b0, fill_vpn}, {12'b0, va[31:12]});
    chk(fill_ppn === e_ppn, "R6 ppn", {12'b0, fill_ppn}, {12'b0, e_ppn});
    chk(fill_access === e_acc, "R6 access", {29'b0, fill_access}, {29'b0, e_acc});
    chk(fill_paddr === (e_fault ? 32'h0 : {e_ppn, va[11:0]}), "R6 paddr", fill_paddr,
        e_fault ? 32'h0 : {e_ppn, va[11:0]});
    @(negedge clk);
    chk(fill_valid === 1'b0 && busy === 1'b0, "R10 pulse end",
        {30'b0, fill_valid, busy}, 32'd0);
    @(negedge clk);
    chk(busy === 1'b0 && log_n == e_reads, "R2 stray miss ignored", 32'(log_n), 32'(e_reads));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && mem_req_valid === 1'b0 && fill_valid === 1'b0, "R1 in reset",
        {29'b0, busy, mem_req_valid, fill_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && mem_req_valid === 1'b0 && fill_valid === 1'b0, "R1 after reset",
        {29'b0, busy, mem_req_valid, fill_valid}, 32'd0);

    set_base(20'h00010);
    // directed corners
    make_map(32'h0000_0000, 1, 1); walk(32'h0000_0000, 0);   // R6 low edge
    make_map(32'hFFFF_FFFF, 1, 1); walk(32'hFFFF_FFFF, 0);   // R6 high edge
    make_map(32'h1234_5ABC, 0, 0); walk(32'h1234_5ABC, 0);   // R7
    make_map(32'h8765_4321, 1, 0); walk(32'h8765_4321, 0);   // R8
    make_map(32'h4000_1FFF, 1, 1); walk(32'h4000_1FFF, 1);   // R2 stray miss
    make_map(32'h0040_2000, 1, 1); walk(32'h0040_2000, 2);   // R9 load while busy
    walk(32'h0040_2000, 0);                                  // R9 base unchanged
    set_base(20'h00020);                                     // R9 load in idle
    make_map(32'h0040_2000, 1, 1); walk(32'h0040_2000, 0);

    for (int i = 0; i < 60; i++) begin
      logic [31:0] va;
      int r;
      if (i % 15 == 7) set_base(20'h00010 + 20'($urandom % 4));
      va = $urandom;
      r  = $urandom % 10;
      make_map(va, r >= 2, r >= 4);
      walk(va, int'($urandom % 4) == 0 ? 1 : 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule